// File: doc/BRIEF.md
# PLL Lock Monitor with Asymmetric Hysteresis

This block produces a lock status flag for a phase-locked loop. An upstream phase comparator raises `phase_err` when the reference and feedback edges are further apart than an acceptable window, roughly 700 ps. That analog comparison is not modelled here. The monitor samples the flag once per feedback clock period. It then applies hysteresis that is deliberately lopsided: a short run of bad feedback periods drops lock, but a much longer run of clean periods is needed before lock is declared again.

A feedback clock that stops would freeze the sampling, so a watchdog guards against it. The watchdog runs on a divided-down copy of the reference clock and is restarted by every feedback edge. If it expires, lock is withdrawn. Each feedback edge, together with the error value captured on it, is carried into the reference domain through a toggle synchronizer. All decision state lives in the reference domain, so `lock` is a clean reference-clock register. No output-enable or master-reset control of the surrounding clock buffer acts on it, and it is always driven.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low at a rising `ref_clk` edge, `lock` is low after that edge.
- R2: `phase_err` is sampled on each rising `fb_clk` edge (1 = that feedback period has a phase error). Each feedback rising edge is one sample, consumed in the reference domain SYNC_STAGES+1 `ref_clk` edges after the edge is first captured.
- R3: While unlocked, `lock` rises on the sample that completes GOOD_LIMIT (default 32) consecutive error-free samples, and not earlier.
- R4: While unlocked, a sample with an error restarts the error-free run from zero.
- R5: While locked, `lock` falls on the sample that completes BAD_LIMIT (default 4) consecutive error samples.
- R6: While locked, an error-free sample restarts the error run from zero, so lock survives any pattern without BAD_LIMIT errors in a row.
- R7: While locked, if no feedback sample arrives for WD_DIV*WD_TICKS (default 128) `ref_clk` cycles after the last one was consumed, `lock` falls on exactly that edge.
- R8: Feedback gaps shorter than the watchdog timeout leave `lock` unchanged.
- R9: A watchdog expiry while unlocked restarts the error-free run, so GOOD_LIMIT fresh clean samples are needed afterwards.
- R10: `lock` changes only on a `ref_clk` edge that consumes a feedback sample or a watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all lock decisions and the watchdog run on it |
| fb_clk | input | 1 | Feedback clock; one phase sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| phase_err | input | 1 | Phase comparator result for the current feedback period |
| lock | output | 1 | High while the PLL is considered locked |

## Verification
A feedback sample is captured on the `fb_clk` rise. It then passes two synchronizer stages and an edge-detect register, so `lock` moves on the third `ref_clk` edge after the rise. The bench drives each feedback period as 20 ns with the rise offset from the reference edges, and it compares `lock` with its model at the end of the period, after that third edge. The watchdog result is due exactly 128 reference cycles after the consuming edge. The bench therefore samples `lock` two nanoseconds before and two nanoseconds after that edge, and idle gaps are kept to whole reference cycles so the alignment holds.

// File: rtl/lockmon_pkg.sv
// Shared types and helpers for the PLL lock monitor.
package lockmon_pkg;

    // Lock decision state: hunting for a clean run, or holding lock.
    typedef enum logic {
        LS_HUNT = 1'b0,
        LS_HOLD = 1'b1
    } lock_state_e;

    // Bits needed to hold the value max_val (at least one).
    function automatic int unsigned width_for(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lockmon_fb_capture.sv
// Feedback sample transfer.
// Captures phase_err and flips a toggle on every rising fb_clk edge, then
// synchronizes the toggle into ref_clk and emits a one-cycle event.
// Assumes the feedback period is longer than SYNC_STAGES+2 reference cycles,
// so the captured error value is stable while the event is consumed.
module lockmon_fb_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic fb_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic phase_err,
    output logic evt,
    output logic evt_err
);
    logic                   fb_toggle_q;
    logic                   fb_err_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;

    // Feedback domain: mark each edge and hold its error sample.
    always_ff @(posedge fb_clk) begin
        if (!rst_n) begin
            fb_toggle_q <= 1'b0;
            fb_err_q    <= 1'b0;
        end else begin
            fb_toggle_q <= ~fb_toggle_q;
            fb_err_q    <= phase_err;
        end
    end

    // Reference domain: synchronizer chain plus edge-detect history.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= (sync_q << 1) | SYNC_STAGES'(fb_toggle_q);
            seen_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign evt     = sync_q[SYNC_STAGES-1] ^ seen_q;
    assign evt_err = fb_err_q;
endmodule

// File: rtl/lockmon_watchdog.sv
// Feedback-loss watchdog.
// A prescaler divides ref_clk by WD_DIV, and a tick counter counts WD_TICKS of
// those ticks. Both restart on every feedback event, so expire pulses exactly
// WD_DIV*WD_TICKS reference cycles after the last event. It repeats with that
// period while feedback stays silent.
module lockmon_watchdog #(
    parameter int WD_DIV   = 8,
    parameter int WD_TICKS = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic kick,
    output logic expire
);
    import lockmon_pkg::*;

    localparam int DIV_W  = width_for(WD_DIV - 1);
    localparam int TICK_W = width_for(WD_TICKS - 1);

    logic [DIV_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    logic              tick_end;
    logic              span_end;

    assign tick_end = (pre_q == DIV_W'(WD_DIV - 1));
    assign span_end = tick_end && (tick_q == TICK_W'(WD_TICKS - 1));
    assign expire   = span_end && !kick;

    // Prescaler and tick count, both cleared by a feedback event.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || kick) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick_end) begin
            pre_q  <= '0;
            tick_q <= span_end ? '0 : tick_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/lockmon_hysteresis.sv
// Lock decision with asymmetric hysteresis.
// One run counter counts consecutive samples that argue against the current
// state: error samples while holding, clean samples while hunting. Any sample
// of the other kind clears it. Reaching the state's limit flips the state.
// A watchdog expiry forces the hunting state with an empty run.
module lockmon_hysteresis #(
    parameter int BAD_LIMIT  = 4,
    parameter int GOOD_LIMIT = 32
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic evt,
    input  logic evt_err,
    input  logic expire,
    output logic lock
);
    import lockmon_pkg::*;

    localparam int LIMIT_MAX = (BAD_LIMIT > GOOD_LIMIT) ? BAD_LIMIT : GOOD_LIMIT;
    localparam int RUN_W     = width_for(LIMIT_MAX);

    lock_state_e      state_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic [RUN_W-1:0] target;
    logic             against;

    // Pick the limit and the sample polarity that counts toward a flip.
    always_comb begin
        run_inc = run_q + 1'b1;
        if (state_q == LS_HOLD) begin
            target  = RUN_W'(BAD_LIMIT);
            against = evt_err;
        end else begin
            target  = RUN_W'(GOOD_LIMIT);
            against = !evt_err;
        end
    end

    // State and run counter update.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || expire) begin
            state_q <= LS_HUNT;
            run_q   <= '0;
        end else if (evt) begin
            if (!against) begin
                run_q <= '0;
            end else if (run_inc == target) begin
                state_q <= (state_q == LS_HOLD) ? LS_HUNT : LS_HOLD;
                run_q   <= '0;
            end else begin
                run_q <= run_inc;
            end
        end
    end

    assign lock = (state_q == LS_HOLD);
endmodule

// File: rtl/pll_lock_monitor.sv
// PLL lock monitor top.
// Joins feedback sample transfer, watchdog and hysteresis. The lock output is
// a reference-domain register, independent of any output-enable control.
// Assumes rst_n is held low for several cycles of both clocks.
module pll_lock_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int BAD_LIMIT   = 4,
    parameter int GOOD_LIMIT  = 32,
    parameter int WD_DIV      = 8,
    parameter int WD_TICKS    = 16
) (
    input  logic ref_clk,
    input  logic fb_clk,
    input  logic rst_n,
    input  logic phase_err,
    output logic lock
);
    logic fb_evt;
    logic fb_evt_err;
    logic wd_expire;

    lockmon_fb_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .fb_clk    (fb_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .phase_err (phase_err),
        .evt       (fb_evt),
        .evt_err   (fb_evt_err)
    );

    lockmon_watchdog #(.WD_DIV(WD_DIV), .WD_TICKS(WD_TICKS)) u_watchdog (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .kick    (fb_evt),
        .expire  (wd_expire)
    );

    lockmon_hysteresis #(.BAD_LIMIT(BAD_LIMIT), .GOOD_LIMIT(GOOD_LIMIT)) u_hyst (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .evt     (fb_evt),
        .evt_err (fb_evt_err),
        .expire  (wd_expire),
        .lock    (lock)
    );
endmodule

// File: rtl/pll_lock_monitor_checker.sv
// Property checker for pll_lock_monitor, attached by bind.
// Relates the lock output to the synchronized feedback events and the
// watchdog expiry pulse. It keeps its own count of clean samples.
module pll_lock_monitor_checker #(
    parameter int GOOD_LIMIT = 32
) (
    input logic ref_clk,
    input logic rst_n,
    input logic lock,
    input logic fb_evt,
    input logic fb_evt_err,
    input logic wd_expire
);
    localparam int CW = $clog2(GOOD_LIMIT + 1);
    logic [CW-1:0] good_seen;

    // Independent count of clean samples seen while unlocked.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || lock || wd_expire) begin
            good_seen <= '0;
        end else if (fb_evt) begin
            good_seen <= fb_evt_err ? '0 : good_seen + 1'b1;
        end
    end

    a_r1_reset_low: assert property (@(posedge ref_clk) !rst_n |=> !lock);

    a_r3_min_good_run: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!lock && fb_evt && !fb_evt_err && good_seen < CW'(GOOD_LIMIT - 1)) |=> !lock);

    a_r4_err_blocks_rise: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!lock && fb_evt && fb_evt_err) |=> !lock);

    a_r6_clean_keeps_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lock && fb_evt && !fb_evt_err && !wd_expire) |=> lock);

    a_r7_expiry_drops: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lock && wd_expire) |=> !lock);

    a_r10_rise_cause: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock) |-> $past(fb_evt && !fb_evt_err));

    a_r10_fall_cause: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lock) |-> $past((fb_evt && fb_evt_err) || wd_expire));
endmodule

bind pll_lock_monitor pll_lock_monitor_checker #(.GOOD_LIMIT(GOOD_LIMIT)) u_checker (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .lock       (lock),
    .fb_evt     (fb_evt),
    .fb_evt_err (fb_evt_err),
    .wd_expire  (wd_expire)
);

// File: tb/test_pll_lock_monitor.sv
// Bench for pll_lock_monitor: directed corners plus seeded random error streams,
// compared with a spec-level model of the hysteresis and watchdog.
module test_pll_lock_monitor;
    localparam int BAD_N   = 4;
    localparam int GOOD_N  = 32;
    localparam int TMO_NS  = 8 * 16 * 4;

    logic ref_clk = 1'b0;
    logic fb_clk  = 1'b0;
    logic rst_n   = 1'b0;
    logic phase_err = 1'b0;
    logic lock;

    int compared   = 0;
    int mismatched = 0;
    logic m_lock = 1'b0;
    int   m_run  = 0;

    pll_lock_monitor i_pll_lock_monitor (
        .ref_clk   (ref_clk),
        .fb_clk    (fb_clk),
        .rst_n     (rst_n),
        .phase_err (phase_err),
        .lock      (lock)
    );

    // 250 MHz reference: rising edges at 4k+2 ns.
    always #2 ref_clk = ~ref_clk;

    // Spec model: next lock state after one feedback sample.
    function automatic logic model_lock(input logic cur, input int run, input logic err);
        if (cur) return !(err && run + 1 == BAD_N);
        return (!err && run + 1 == GOOD_N);
    endfunction

    // Spec model: next run length after one feedback sample.
    function automatic int model_run(input logic cur, input int run, input logic err);
        if (cur == err) begin
            if (run + 1 == (cur ? BAD_N : GOOD_N)) return 0;
            return run + 1;
        end
        return 0;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: lock=%0b expected %0b", req, $time, act, exp);
        end
    endtask

    // One 20 ns feedback period; the rise falls 1 ns after a time 0 mod 4.
    task automatic fb_pulse(input logic err);
        phase_err = err;
        #9 fb_clk = 1'b1;
        #10 fb_clk = 1'b0;
        #1;
    endtask

    // Feedback period with a model update and a check after the third ref edge.
    task automatic fb_cycle(input logic err, input string req);
        logic nl;
        fb_pulse(err);
        nl     = model_lock(m_lock, m_run, err);
        m_run  = model_run(m_lock, m_run, err);
        m_lock = nl;
        check_bit(req, lock, m_lock);
    endtask

    // Feedback silence of n reference cycles, shorter than the timeout.
    task automatic idle_short(input int n, input string req);
        #(4 * n);
        check_bit(req, lock, m_lock);
    endtask

    initial begin
        #800000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: run hung, lock=%0b expected completion", lock);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset held across feedback pulses so both domains clear.
        for (int i = 0; i < 3; i++) fb_pulse(1'b0);
        check_bit("R1 during reset", lock, 1'b0);
        rst_n = 1'b1;
        #8;
        check_bit("R1 after release", lock, 1'b0);

        // R3/R4: 31 clean, one error, then a full clean run.
        for (int i = 0; i < GOOD_N - 1; i++) fb_cycle(1'b0, "R3 short run");
        fb_cycle(1'b1, "R4 error restarts");
        for (int i = 0; i < GOOD_N - 1; i++) fb_cycle(1'b0, "R4 run after error");
        fb_cycle(1'b0, "R3 lock on final clean sample");
        check_bit("R3 locked", lock, 1'b1);

        // R6: errors broken by clean samples keep lock.
        for (int i = 0; i < BAD_N - 1; i++) fb_cycle(1'b1, "R6 bad run");
        fb_cycle(1'b0, "R6 clean breaks run");
        for (int i = 0; i < BAD_N - 1; i++) fb_cycle(1'b1, "R6 second bad run");
        fb_cycle(1'b0, "R6 clean breaks again");
        check_bit("R6 still locked", lock, 1'b1);

        // R5: four in a row drop lock on the fourth.
        for (int i = 0; i < BAD_N; i++) fb_cycle(1'b1, "R5 bad streak");
        check_bit("R5 dropped", lock, 1'b0);
        idle_short(60, "R10 unlocked silence");

        // Regain, then R8 gap below timeout.
        for (int i = 0; i < GOOD_N; i++) fb_cycle(1'b0, "R2 relock");
        idle_short(100, "R8 short gap");
        fb_cycle(1'b0, "R8 resume");

        // R7: feedback stops; expiry edge is 18+512 ns after the last period start.
        #(TMO_NS - 4);
        check_bit("R7 before timeout", lock, 1'b1);
        #4;
        check_bit("R7 after timeout", lock, 1'b0);
        m_lock = 1'b0;
        m_run  = 0;

        // R9: a partial clean run is wiped by an expiry while unlocked.
        for (int i = 0; i < 20; i++) fb_cycle(1'b0, "R9 partial run");
        #600;
        m_run = 0;
        check_bit("R9 silent while unlocked", lock, 1'b0);
        for (int i = 0; i < GOOD_N - 1; i++) fb_cycle(1'b0, "R9 not yet");
        fb_cycle(1'b0, "R9 full fresh run");

        // Random error streams with phases of low and high error rate.
        for (int blk = 0; blk < 30; blk++) begin
            int rate = (blk % 2 == 0) ? 40 : 2;
            for (int i = 0; i < 50; i++) begin
                logic e = ($urandom % rate) == 0;
                fb_cycle(e, "R2 random sample");
                if ($urandom % 16 == 0) idle_short($urandom % 60, "R8 random gap");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule